// File: doc/BRIEF.md
# Multiplexed LCD Common/Segment Scanner

This block turns a small display memory into drive codes for a passive LCD panel with 8 common lines and 32 segment lines, 256 pixels in all, scanned at 1/8 duty. It runs from a 32768 Hz system clock. Each common line is selected for 64 clocks, so one frame takes 512 clocks and the frame rate is 64 Hz. The outputs are 3-bit level codes, one per pin. An external analog stage turns each code into one of the five voltages of a 1/4-bias scheme.

The display memory holds 64 words of 4 bits. Segment n uses two consecutive words. The block reads that memory through a synchronous read port with one cycle of latency. During each common period it fetches the 32 pixel bits that the next common period needs. The drive polarity is inverted every frame, so no pixel carries a DC average. Two controls come from the system command decoder. The system enable starts and stops the scanner. The display-on control blanks the panel without touching memory.

The control FSM has four states:
- ST_OFF: system disabled. This is the reset state.
- ST_DARK: system enabled, display off.
- ST_PRIME: one common period in which the first pixel set is fetched while the outputs stay blank.
- ST_SCAN: normal drive.

Transitions:
- ST_OFF goes to ST_PRIME when the system enable and display-on are both high. It goes to ST_DARK when only the system enable is high.
- ST_DARK goes to ST_PRIME when display-on rises.
- ST_PRIME goes to ST_SCAN at the end of its 64-clock period.
- ST_PRIME and ST_SCAN fall back to ST_DARK when display-on drops.
- Every state goes to ST_OFF when the system enable drops.

Top module: `lcd_mux_scanner`

## Requirements
- R1: After reset the block is in the system-off state and every common and segment output carries level code 0.
- R2: Each output code is a 3-bit unsigned value k meaning k quarters of the LCD supply, with k from 0 to 4. Segment outputs only ever carry 0, 2 or 4.
- R3: Each common is selected for exactly 64 clocks. Commons are selected in the order 0 to 7, so a frame is 512 clocks.
- R4: The pixel of segment n on common c is bit (c mod 4) of memory word 2n + (c div 4). Word 2n therefore holds commons 0 to 3, and word 2n+1 holds commons 4 to 7.
- R5: The first frame after drive starts has normal polarity, and frames then alternate.
  - Normal frame: the selected common is 4, unselected commons are 1, a lit segment is 0 and an unlit segment is 2.
  - Inverted frame: the selected common is 0, unselected commons are 3, a lit segment is 4 and an unlit segment is 2.
- R6: Consider the clock edge that samples system enable and display-on both high while the block is in ST_OFF or ST_DARK. The outputs stay at code 0 through the next 63 edges. The 64th edge after it loads common 0 with normal polarity.
- R7: When display-on is sampled low, every output is code 0 after that edge. Memory is not written. When display-on is raised again, the same memory image is shown, starting from common 0 with normal polarity, with the R6 timing.
- R8: When system enable is sampled low, the block enters ST_OFF and every output is code 0 after that edge, whatever display-on is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_en | input | 1 | System enable, from the system on/off commands |
| disp_on | input | 1 | Display on (1) or blanked (0) |
| rd_addr | output | 6 | Display memory read address |
| rd_data | input | 4 | Display memory read data, valid one clock after the address |
| com_lvl | output | 24 | Level codes; common c occupies bits [3c+2:3c] |
| seg_lvl | output | 96 | Level codes; segment n occupies bits [3n+2:3n] |

## Verification
The scan is driven with three memory images:
- An arithmetic ramp, where every word differs from its neighbours. A wrong choice between the two words of a segment, or a wrong segment index, shows up as a mismatch.
- Alternating nibbles 0x5 and 0xA, which expose a reversed bit order within a word and a swap of the lower and upper common halves.
- A scrambled image, shown after an entry that was cut short in ST_PRIME. It shows whether the counters restart cleanly.

Each run covers at least one full normal frame and one full inverted frame, so a polarity error cannot hide behind a symmetric pattern. Runs are entered from ST_OFF and from ST_DARK. The blank window before the first common period is checked at both ends.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int LVL_W = 3;

    // drive level codes, in quarters of the LCD supply
    localparam logic [LVL_W-1:0] LV_0  = 3'd0;
    localparam logic [LVL_W-1:0] LV_1Q = 3'd1;
    localparam logic [LVL_W-1:0] LV_2Q = 3'd2;
    localparam logic [LVL_W-1:0] LV_3Q = 3'd3;
    localparam logic [LVL_W-1:0] LV_4Q = 3'd4;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_DARK  = 2'd1,
        ST_PRIME = 2'd2,
        ST_SCAN  = 2'd3
    } scan_state_e;

endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
    import lcd_scan_pkg::*;
#(
    parameter int NUM_COM      = 8,
    parameter int NUM_SEG      = 32,
    parameter int CLKS_PER_COM = 64,
    localparam int COM_W       = $clog2(NUM_COM),
    localparam int CYC_W       = $clog2(CLKS_PER_COM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sys_en,
    input  logic             disp_on,
    output logic [CYC_W-1:0] cyc,
    output logic [COM_W-1:0] tgt_com,
    output logic             tgt_pol,
    output logic             fetch_run,
    output logic             load,
    output logic             drive_en
);

    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(CLKS_PER_COM - 1);
    localparam logic [CYC_W-1:0] SEG_CYCS = CYC_W'(NUM_SEG);
    localparam logic [COM_W-1:0] LAST_COM = COM_W'(NUM_COM - 1);

    scan_state_e      state_q, state_nx;
    logic [CYC_W-1:0] cyc_q;
    logic [COM_W-1:0] cur_com_q;
    logic             cur_pol_q;
    logic             running;
    logic             period_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (sys_en) state_nx = disp_on ? ST_PRIME : ST_DARK;
            end
            ST_DARK: begin
                if (!sys_en)      state_nx = ST_OFF;
                else if (disp_on) state_nx = ST_PRIME;
            end
            ST_PRIME: begin
                if (!sys_en)         state_nx = ST_OFF;
                else if (!disp_on)   state_nx = ST_DARK;
                else if (period_end) state_nx = ST_SCAN;
            end
            ST_SCAN: begin
                if (!sys_en)       state_nx = ST_OFF;
                else if (!disp_on) state_nx = ST_DARK;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // outputs derived from the current state
    always_comb begin
        running    = (state_q == ST_PRIME) || (state_q == ST_SCAN);
        period_end = running && (cyc_q == LAST_CYC);
        if (state_q == ST_SCAN) begin
            tgt_com = (cur_com_q == LAST_COM) ? '0 : cur_com_q + 1'b1;
            tgt_pol = cur_pol_q ^ (cur_com_q == LAST_COM);
        end else begin
            tgt_com = cur_com_q;
            tgt_pol = cur_pol_q;
        end
        fetch_run = running && (cyc_q < SEG_CYCS);
        load      = period_end && (state_nx == ST_SCAN);
        drive_en  = (state_nx == ST_SCAN);
        cyc       = cyc_q;
    end

    // period counter, current common and frame polarity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q     <= '0;
            cur_com_q <= '0;
            cur_pol_q <= 1'b0;
        end else if (!running) begin
            cyc_q     <= '0;
            cur_com_q <= '0;
            cur_pol_q <= 1'b0;
        end else begin
            cyc_q <= period_end ? '0 : cyc_q + 1'b1;
            if ((state_q == ST_SCAN) && period_end) begin
                cur_com_q <= tgt_com;
                cur_pol_q <= tgt_pol;
            end
        end
    end

    AST_COM_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && load) |=> (cur_com_q != $past(cur_com_q))) else $error("common did not advance"); // R3
    AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && load && cur_com_q == LAST_COM) |=> (cur_pol_q != $past(cur_pol_q))) else $error("polarity kept across frame"); // R5
    AST_OFF_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_en |=> (state_q == ST_OFF)) else $error("not off after disable"); // R8

endmodule

// File: rtl/lcd_seg_fetch.sv
module lcd_seg_fetch #(
    parameter int NUM_COM      = 8,
    parameter int NUM_SEG      = 32,
    parameter int WORD_W       = 4,
    parameter int CLKS_PER_COM = 64,
    localparam int COM_W       = $clog2(NUM_COM),
    localparam int CYC_W       = $clog2(CLKS_PER_COM),
    localparam int WPS         = NUM_COM / WORD_W,
    localparam int ADDR_W      = $clog2(NUM_SEG * WPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CYC_W-1:0]  cyc,
    input  logic [COM_W-1:0]  tgt_com,
    input  logic              fetch_run,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic [NUM_SEG-1:0] shadow
);

    localparam int SEG_W = $clog2(NUM_SEG);
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [SEG_W-1:0] cap_idx_q;
    logic [BIT_W-1:0] cap_bit_q;
    logic             cap_vld_q;

    // one read per segment in the first NUM_SEG cycles of a period
    always_comb begin
        if (fetch_run)
            rd_addr = ADDR_W'(cyc[SEG_W-1:0]) * ADDR_W'(WPS) + ADDR_W'(tgt_com / COM_W'(WORD_W));
        else
            rd_addr = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_vld_q <= 1'b0;
            cap_idx_q <= '0;
            cap_bit_q <= '0;
            shadow    <= '0;
        end else begin
            cap_vld_q <= fetch_run;
            cap_idx_q <= cyc[SEG_W-1:0];
            cap_bit_q <= BIT_W'(tgt_com % COM_W'(WORD_W));
            if (cap_vld_q) shadow[cap_idx_q] <= rd_data[cap_bit_q];
        end
    end

endmodule

// File: rtl/lcd_level_drive.sv
module lcd_level_drive
    import lcd_scan_pkg::*;
#(
    parameter int NUM_COM = 8,
    parameter int NUM_SEG = 32,
    localparam int COM_W  = $clog2(NUM_COM)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     drive_en,
    input  logic                     load,
    input  logic [COM_W-1:0]         tgt_com,
    input  logic                     tgt_pol,
    input  logic [NUM_SEG-1:0]       shadow,
    output logic [NUM_COM*LVL_W-1:0] com_lvl,
    output logic [NUM_SEG*LVL_W-1:0] seg_lvl
);

    logic [LVL_W-1:0] com_q [NUM_COM];
    logic [LVL_W-1:0] seg_q [NUM_SEG];
    logic             active_q;
    logic [NUM_COM-1:0] sel_vec;
    logic [NUM_COM-1:0] com4_vec;
    logic [NUM_SEG-1:0] seg4_vec;
    logic [NUM_SEG-1:0] seg_bad;

    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        com_q[c] <= LV_0;
            else if (!drive_en) com_q[c] <= LV_0;
            else if (load) begin
                if (tgt_com == COM_W'(c)) com_q[c] <= tgt_pol ? LV_0  : LV_4Q;
                else                      com_q[c] <= tgt_pol ? LV_3Q : LV_1Q;
            end
        end
        assign com_lvl[c*LVL_W +: LVL_W] = com_q[c];
        assign sel_vec[c]  = (com_q[c] == LV_0) || (com_q[c] == LV_4Q);
        assign com4_vec[c] = (com_q[c] == LV_4Q);
    end

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         seg_q[s] <= LV_0;
            else if (!drive_en) seg_q[s] <= LV_0;
            else if (load)      seg_q[s] <= shadow[s] ? (tgt_pol ? LV_4Q : LV_0) : LV_2Q;
        end
        assign seg_lvl[s*LVL_W +: LVL_W] = seg_q[s];
        assign seg4_vec[s] = (seg_q[s] == LV_4Q);
        assign seg_bad[s]  = seg_q[s][0] || (seg_q[s] > LV_4Q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         active_q <= 1'b0;
        else if (!drive_en) active_q <= 1'b0;
        else if (load)      active_q <= 1'b1;
    end

    AST_ONE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> ($countones(sel_vec) == 1)) else $error("not exactly one common selected"); // R5
    AST_SEG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        seg_bad == '0) else $error("illegal segment code"); // R2
    AST_POL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && com4_vec != '0) |-> (seg4_vec == '0)) else $error("segment and common share polarity"); // R5

endmodule

// File: rtl/lcd_mux_scanner.sv
module lcd_mux_scanner
    import lcd_scan_pkg::*;
#(
    parameter int NUM_COM      = 8,
    parameter int NUM_SEG      = 32,
    parameter int WORD_W       = 4,
    parameter int CLKS_PER_COM = 64,
    localparam int COM_W       = $clog2(NUM_COM),
    localparam int CYC_W       = $clog2(CLKS_PER_COM),
    localparam int ADDR_W      = $clog2(NUM_SEG * (NUM_COM / WORD_W))
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sys_en,
    input  logic                     disp_on,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic [WORD_W-1:0]        rd_data,
    output logic [NUM_COM*LVL_W-1:0] com_lvl,
    output logic [NUM_SEG*LVL_W-1:0] seg_lvl
);

    logic [CYC_W-1:0]   cyc;
    logic [COM_W-1:0]   tgt_com;
    logic               tgt_pol;
    logic               fetch_run;
    logic               load;
    logic               drive_en;
    logic [NUM_SEG-1:0] shadow;

    lcd_scan_ctrl #(
        .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .CLKS_PER_COM(CLKS_PER_COM)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sys_en(sys_en), .disp_on(disp_on),
        .cyc(cyc), .tgt_com(tgt_com), .tgt_pol(tgt_pol),
        .fetch_run(fetch_run), .load(load), .drive_en(drive_en)
    );

    lcd_seg_fetch #(
        .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG), .WORD_W(WORD_W), .CLKS_PER_COM(CLKS_PER_COM)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .cyc(cyc), .tgt_com(tgt_com),
        .fetch_run(fetch_run), .rd_addr(rd_addr), .rd_data(rd_data), .shadow(shadow)
    );

    lcd_level_drive #(
        .NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)
    ) u_drive (
        .clk(clk), .rst_n(rst_n), .drive_en(drive_en), .load(load),
        .tgt_com(tgt_com), .tgt_pol(tgt_pol), .shadow(shadow),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (com_lvl == '0 && seg_lvl == '0) else $error("outputs active in reset"); // R1
        end
    end

    AST_DISPOFF_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> (com_lvl == '0 && seg_lvl == '0)) else $error("drive while display off"); // R7
    AST_SYSOFF_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_en |=> (com_lvl == '0 && seg_lvl == '0)) else $error("drive while system off"); // R8

endmodule

// File: tb/lcd_mux_scanner_tb.sv
module lcd_mux_scanner_tb_top;

    localparam int NC = 8;
    localparam int NS = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sys_en = 1'b0;
    logic            disp_on = 1'b0;
    logic [5:0]      rd_addr;
    logic [3:0]      rd_data = '0;
    logic [NC*3-1:0] com_lvl;
    logic [NS*3-1:0] seg_lvl;
    logic [3:0]      mem [64];

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    always @(posedge clk) rd_data <= mem[rd_addr];

    lcd_mux_scanner dut_i (
        .clk(clk), .rst_n(rst_n), .sys_en(sys_en), .disp_on(disp_on),
        .rd_addr(rd_addr), .rd_data(rd_data), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    function automatic logic [NC*3-1:0] exp_com(input int c, input int pol);
        logic [NC*3-1:0] v;
        for (int i = 0; i < NC; i++)
            v[i*3 +: 3] = (i == c) ? ((pol != 0) ? 3'd0 : 3'd4) : ((pol != 0) ? 3'd3 : 3'd1);
        return v;
    endfunction

    function automatic logic [NS*3-1:0] exp_seg(input int c, input int pol);
        logic [NS*3-1:0] v;
        for (int n = 0; n < NS; n++) begin
            logic [3:0] w;
            w = mem[2*n + c/4];
            v[n*3 +: 3] = w[c%4] ? ((pol != 0) ? 3'd4 : 3'd0) : 3'd2;
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_blank(input string tag);
        chk({tag, " commons blank"}, 128'(com_lvl), 128'(0));
        chk({tag, " segments blank"}, 128'(seg_lvl), 128'(0));
    endtask

    task automatic load_mem(input int which);
        for (int a = 0; a < 64; a++) begin
            case (which)
                0:       mem[a] = 4'((a * 5 + 3) % 16);
                1:       mem[a] = (a % 2 == 0) ? 4'h5 : 4'hA;
                default: mem[a] = 4'(((a * 11) ^ (a / 4)) % 16);
            endcase
        end
    endtask

    // caller has just made the enabling change at a negedge
    task automatic scan_run(input int periods, input string pref);
        repeat (32) @(negedge clk);
        chk_blank({pref, " R6 mid-prime"});
        repeat (32) @(negedge clk);
        chk_blank({pref, " R6 end-prime"});
        @(negedge clk);
        for (int k = 0; k < periods; k++) begin
            if (k > 0) repeat (64) @(negedge clk);
            chk($sformatf("%s R3 R5 commons period %0d", pref, k),
                128'(com_lvl), 128'(exp_com(k % 8, (k / 8) % 2)));
            chk($sformatf("%s R4 R5 segments period %0d", pref, k),
                128'(seg_lvl), 128'(exp_seg(k % 8, (k / 8) % 2)));
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_up();
    end

    initial begin
        load_mem(0);
        repeat (4) @(negedge clk);
        chk_blank("R1 during reset");
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk_blank("R1 after reset");

        // ramp image, entered straight from system-off
        sys_en = 1'b1;
        disp_on = 1'b1;
        scan_run(17, "ramp");

        // display off keeps memory; R7
        @(negedge clk);
        disp_on = 1'b0;
        @(negedge clk);
        chk_blank("R7 display off");
        repeat (50) @(negedge clk);
        chk_blank("R7 display off held");
        disp_on = 1'b1;
        scan_run(9, "R7 reshow");

        // system off, then alternating nibbles; R8
        @(negedge clk);
        sys_en = 1'b0;
        @(negedge clk);
        chk_blank("R8 system off");
        repeat (20) @(negedge clk);
        chk_blank("R8 system off held");
        load_mem(1);
        sys_en = 1'b1;
        scan_run(17, "R8 nibble");

        // scrambled image after an aborted prime, entered from dark state
        @(negedge clk);
        disp_on = 1'b0;
        @(negedge clk);
        load_mem(2);
        disp_on = 1'b1;
        repeat (20) @(negedge clk);
        disp_on = 1'b0;
        @(negedge clk);
        chk_blank("R7 prime aborted");
        disp_on = 1'b1;
        scan_run(17, "R6 scrambled");

        finish_up();
    end

endmodule